// File: doc/BRIEF.md
# BCD Calendar Clock with Century

This block keeps wall-clock time and calendar date in packed BCD. It runs from a 32.768 kHz clock and divides it internally to a one-second advance. It holds seconds, minutes, hours (24-hour form), day of week, date, month, two-digit year and a century count. A single one-second advance ripples through every field in the same clock cycle. That ripple takes in month lengths, the leap-year rule and the century step. The host never observes a half-updated time.

The host loads any one field per clock through a narrow write port: a select, a byte and an enable. A load also restarts the sub-second divider. The next advance therefore comes one full second after the most recent load, which lets software set the time and release it at a known instant. Timekeeping itself never depends on host activity.

Top module: `bcd_calendar`

## Requirements
- R1: While rst_ni is low and after its release, the fields read cent=20, year=00, month=01, date=01, dow=1, hour=00, min=00, sec=00.
- R2: With no host write, the time advances by one second exactly once every DIV clocks (DIV defaults to 32768), and every field holds its value on all other clocks.
- R3: Seconds and minutes count 00..59 in BCD, carry from digit 9 to the tens digit, and wrap 59 to 00 while advancing the next field.
- R4: Hours count 00..23 and wrap to 00, advancing both the date and the day of week.
- R5: Day of week counts 1..7 and wraps 7 to 1 at each midnight, independent of the date.
- R6: The date wraps to 01 after 31 in months 01, 03, 05, 07, 08, 10, 12 and after 30 in months 04, 06, 09, 11, and the month then advances.
- R7: In month 02 the date wraps after 29 when the BCD year is divisible by four (00 included) and after 28 otherwise.
- R8: Month 12 wraps to 01 and advances the year; year 99 wraps to 00 and advances the BCD century, which itself wraps 99 to 00.
- R9: With wr_en_i high, the field picked by wr_sel_i (0 sec, 1 min, 2 hour, 3 dow, 4 date, 5 month, 6 year, 7 century) takes wr_data_i on that clock edge, and the next advance follows DIV clocks after that edge.
- R10: A write on the clock where an advance was due wins: the written field takes the new value, no other field changes, and the advance is dropped.
- R11: All carries of one advance appear together on the first clock after the advancing edge, including a full rollover from 23:59:59 on 31 Dec of year 99.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32.768 kHz timebase |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Field load enable |
| wr_sel_i | input | 3 | Field select for a load |
| wr_data_i | input | 8 | Packed BCD value to load |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD 00..23 |
| dow_o | output | 8 | Day of week, 1..7 |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Two-digit year, BCD |
| cent_o | output | 8 | Century, BCD |

## Verification
A host load and the one-second advance can land on the same clock. The bench provokes this by loading a time, waiting DIV-1 clocks, and then writing the minutes field on the edge where the advance is due. The write is judged correct when the minutes show the written value, the seconds and all other fields stay put, and the next advance arrives exactly DIV clocks after the colliding write.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;
  localparam int NFLD = 8;

  typedef enum logic [2:0] {
    F_SEC, F_MIN, F_HOUR, F_DOW, F_DATE, F_MON, F_YEAR, F_CENT
  } fld_e;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] fld_lo(input int i);
    return (i == F_DOW || i == F_DATE || i == F_MON) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [7:0] fld_hi(input int i);
    case (i)
      F_SEC, F_MIN:   return 8'h59;
      F_HOUR:         return 8'h23;
      F_DOW:          return 8'h07;
      F_MON:          return 8'h12;
      default:        return 8'h99;
    endcase
  endfunction

  // field whose wrap advances field i
  function automatic int carry_src(input int i);
    case (i)
      F_DOW, F_DATE: return F_HOUR;
      default:       return i - 1;
    endcase
  endfunction
endpackage

// File: rtl/bcd_cal_prescaler.sv
module bcd_cal_prescaler #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST) && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i || cnt_q == LAST) cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bcd_cal_step.sv
module bcd_cal_step (
  input  logic       en_i,
  input  logic [7:0] val_i,
  input  logic [7:0] lo_i,
  input  logic [7:0] hi_i,
  output logic [7:0] nxt_o,
  output logic       carry_o
);
  import bcd_cal_pkg::*;

  // >= so an out-of-range loaded value still wraps
  assign carry_o = en_i && (val_i >= hi_i);

  always_comb begin
    if (!en_i)        nxt_o = val_i;
    else if (carry_o) nxt_o = lo_i;
    else              nxt_o = bcd_inc(val_i);
  end
endmodule

// File: rtl/bcd_cal_month_len.sv
module bcd_cal_month_len (
  input  logic [7:0] month_i,
  input  logic       leap_i,
  output logic [7:0] last_o
);
  always_comb begin
    case (month_i)
      8'h02:                      last_o = leap_i ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
      default:                    last_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar #(
  parameter int unsigned DIV      = 32768,
  parameter logic [7:0]  RST_CENT = 8'h20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [2:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic [7:0] cent_o
);
  import bcd_cal_pkg::*;

  logic       tick;
  logic       leap;
  logic [7:0] last_date;
  logic [7:0] fld_q [NFLD];
  logic [7:0] nxt_w [NFLD];
  logic       en_w  [NFLD];
  logic       cy_w  [NFLD];

  bcd_cal_prescaler #(.DIV(DIV)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (wr_en_i),
    .tick_o(tick)
  );

  // year divisible by four, read straight from BCD digits
  assign leap = ~fld_q[F_YEAR][0] & (fld_q[F_YEAR][1] == fld_q[F_YEAR][4]);

  bcd_cal_month_len u_mlen (
    .month_i(fld_q[F_MON]),
    .leap_i (leap),
    .last_o (last_date)
  );

  for (genvar i = 0; i < NFLD; i++) begin : g_fld
    logic [7:0] hi;
    if (i == 0) begin : g_en_tick
      assign en_w[i] = tick;
    end else begin : g_en_carry
      assign en_w[i] = cy_w[carry_src(i)];
    end
    if (i == F_DATE) begin : g_hi_month
      assign hi = last_date;
    end else begin : g_hi_const
      assign hi = fld_hi(i);
    end
    bcd_cal_step u_step (
      .en_i   (en_w[i]),
      .val_i  (fld_q[i]),
      .lo_i   (fld_lo(i)),
      .hi_i   (hi),
      .nxt_o  (nxt_w[i]),
      .carry_o(cy_w[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NFLD; i++) fld_q[i] <= fld_lo(i);
      fld_q[F_CENT] <= RST_CENT;
    end else if (wr_en_i) begin
      fld_q[wr_sel_i] <= wr_data_i;
    end else begin
      for (int i = 0; i < NFLD; i++) fld_q[i] <= nxt_w[i];
    end
  end

  assign sec_o   = fld_q[F_SEC];
  assign min_o   = fld_q[F_MIN];
  assign hour_o  = fld_q[F_HOUR];
  assign dow_o   = fld_q[F_DOW];
  assign date_o  = fld_q[F_DATE];
  assign month_o = fld_q[F_MON];
  assign year_o  = fld_q[F_YEAR];
  assign cent_o  = fld_q[F_CENT];
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk #(
  parameter int unsigned DIV = 32768
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [2:0] wr_sel_i,
  input logic [7:0] wr_data_i,
  input logic       tick_i,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o,
  input logic [7:0] cent_o
);
  import bcd_cal_pkg::*;

  int unsigned gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                gap_q <= 0;
    else if (tick_i || wr_en_i) gap_q <= 0;
    else                        gap_q <= gap_q + 1;
  end

  AST_TICK_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> gap_q == DIV - 1); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i && !tick_i |=> $stable(sec_o) && $stable(min_o) && $stable(hour_o)
      && $stable(date_o) && $stable(month_o) && $stable(year_o) && $stable(cent_o)); // R2

  AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && sec_o == 8'h59 |=> sec_o == 8'h00 && min_o != $past(min_o)); // R3

  AST_HOUR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && hour_o == 8'h23 && min_o == 8'h59 && sec_o == 8'h59
      |=> hour_o == 8'h00 && date_o != $past(date_o)); // R4

  AST_FULL_ROLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && year_o == 8'h99 && month_o == 8'h12 && date_o == 8'h31
      && hour_o == 8'h23 && min_o == 8'h59 && sec_o == 8'h59
      |=> year_o == 8'h00 && month_o == 8'h01 && date_o == 8'h01
      && cent_o != $past(cent_o)); // R11

  AST_WR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_sel_i == F_MIN |=> min_o == $past(wr_data_i)); // R9

  AST_WR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !tick_i); // R9

  AST_WR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_sel_i != F_SEC |=> $stable(sec_o)); // R10
endmodule

bind bcd_calendar bcd_calendar_chk #(.DIV(DIV)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_sel_i (wr_sel_i),
  .wr_data_i(wr_data_i),
  .tick_i   (tick),
  .sec_o    (sec_o),
  .min_o    (min_o),
  .hour_o   (hour_o),
  .date_o   (date_o),
  .month_o  (month_o),
  .year_o   (year_o),
  .cent_o   (cent_o)
);

// File: tb/bcd_calendar_bench.sv
module bcd_calendar_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 8;
  localparam int NV = 16;

  // {pre, post}, each {cent,year,month,date,dow,hour,min,sec}
  localparam logic [127:0] VEC [NV] = '{
    128'h20_24_06_15_03_00_00_00__20_24_06_15_03_00_00_01, // R2
    128'h20_24_06_15_03_12_34_59__20_24_06_15_03_12_35_00, // R3
    128'h20_24_06_15_03_09_59_59__20_24_06_15_03_10_00_00, // R3
    128'h20_24_12_15_02_23_59_59__20_24_12_16_03_00_00_00, // R4
    128'h20_24_06_15_07_23_59_59__20_24_06_16_01_00_00_00, // R5
    128'h20_24_04_30_01_23_59_59__20_24_05_01_02_00_00_00, // R6
    128'h20_24_01_30_02_23_59_59__20_24_01_31_03_00_00_00, // R6
    128'h20_24_07_31_05_23_59_59__20_24_08_01_06_00_00_00, // R6
    128'h20_24_09_30_07_23_59_59__20_24_10_01_01_00_00_00, // R6
    128'h20_24_02_28_03_23_59_59__20_24_02_29_04_00_00_00, // R7
    128'h20_23_02_28_03_23_59_59__20_23_03_01_04_00_00_00, // R7
    128'h20_24_02_29_05_23_59_59__20_24_03_01_06_00_00_00, // R7
    128'h21_00_02_28_06_23_59_59__21_00_02_29_07_00_00_00, // R7
    128'h20_26_02_28_07_23_59_59__20_26_03_01_01_00_00_00, // R7
    128'h20_99_12_31_07_23_59_59__21_00_01_01_01_00_00_00, // R8 R11
    128'h99_99_12_31_07_23_59_59__00_00_01_01_01_00_00_00  // R8
  };

  localparam string VREQ [NV] = '{"R2", "R3", "R3", "R4", "R5", "R6", "R6", "R6",
                                  "R6", "R7", "R7", "R7", "R7", "R7", "R11", "R8"};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] sec, min, hour, dow, date, month, year, cent;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bcd_calendar #(.DIV(DIV)) u_bcd_calendar (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .sec_o(sec), .min_o(min), .hour_o(hour), .dow_o(dow),
    .date_o(date), .month_o(month), .year_o(year), .cent_o(cent)
  );

  function automatic logic [63:0] now();
    return {cent, year, month, date, dow, hour, min, sec};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(posedge clk);
  endtask

  task automatic wr_end();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input logic [63:0] t);
    for (int i = 0; i < 8; i++) wr(3'(i), t[i*8 +: 8]);
    wr_end();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] t;
    repeat (3) @(negedge clk);
    chk("R1 in reset", now(), 64'h20_00_01_01_01_00_00_00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", now(), 64'h20_00_01_01_01_00_00_00);

    for (int v = 0; v < NV; v++) begin
      load(VEC[v][127:64]);
      repeat (DIV - 1) @(posedge clk);
      @(negedge clk);
      chk("R9 load held until full period", now(), VEC[v][127:64]);
      @(posedge clk);
      @(negedge clk);
      chk(VREQ[v], now(), VEC[v][63:0]);
    end

    // R10: write lands on the edge where the advance is due
    t = 64'h20_24_06_15_03_10_20_30;
    load(t);
    repeat (DIV - 1) @(posedge clk);
    wr(3'd1, 8'h11);
    wr_end();
    chk("R10 write wins over tick", now(), 64'h20_24_06_15_03_10_11_30);
    repeat (DIV - 1) @(posedge clk);
    @(negedge clk);
    chk("R9 prescaler restarted", now(), 64'h20_24_06_15_03_10_11_30);
    @(posedge clk);
    @(negedge clk);
    chk("R9 advance one period after write", now(), 64'h20_24_06_15_03_10_11_31);

    // R2: free running, several consecutive seconds
    for (int k = 0; k < 3; k++) begin
      repeat (DIV) @(posedge clk);
      @(negedge clk);
    end
    chk("R2 three more seconds", now(), 64'h20_24_06_15_03_10_11_34);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule